// File: doc/BRIEF.md
# Round-Robin Row-Slice Scheduler for a Shared Image Pipeline

This block lets four image streams take turns on a single downstream processing pipeline. Software or a sequencer presents the frame height and width of each stream, a per-stream slice size in rows, a row multiplier and a width padding term, then pulses a start input. The scheduler then visits the streams in a fixed rotation. On each visit it works out how many rows of that stream to hand over. It also notes whether this is the stream's final slice of the frame, and computes the read and write word offsets into that stream's buffers.

The row multiplier covers inputs that carry several interleaved exposures per row. A stream with no rows left is passed over without a dispatch. When every stream's scaled height has been consumed, the run ends with a one-cycle completion pulse. Each dispatched slice is presented as a descriptor with a valid flag and is held until the pipeline reports that slice finished on a ready input.

Top module: `mstream_slice_sched`

## Requirements
- R1: Streams are visited in the order 0,1,2,3,0,... A visit to stream 3, whether it dispatches or is skipped, is followed by stream 0 with the slice index one higher. The slice index is 0 for the first rotation of every run.
- R2: The row count of a visit is the stream's slice size when its remaining rows exceed that size, and otherwise the remaining rows. Remaining rows start at the stream's height. Slice size and row multiplier are at least 1.
- R3: Each stream has one end-of-frame flag (bit i of `streamEof` is stream i). All flags clear on start. A visit that takes the remaining-rows path sets the flag to 1, and a visit that takes the slice-size path clears it to 0. `sliceLast` shows the flag of the stream being dispatched.
- R4: A visit whose row count is zero raises no `sliceValid`, and the rotation moves on to the next stream.
- R5: Each finished slice adds rows × multiplier to a consumed total. When the total reaches the sum of height × multiplier over all streams, `schedDone` is high for exactly one cycle, and `busy` is low in the following cycle.
- R6: Each stream has its own read offset. It starts at 0, and each finished slice adds (multiplier × rows × ((width + padding) >> PPC_LOG2)) / 4, truncated per slice. `sliceRdOff` shows the value before the add.
- R7: Each stream has its own write offset. It starts at 0, and each finished slice adds (rows × (width >> PPC_LOG2)) / 4, truncated per slice. `sliceWrOff` shows the value before the add.
- R8: While `sliceValid` is high and `sliceReady` is low, all descriptor outputs stay unchanged. A cycle with both high retires exactly one slice.
- R9: The configuration inputs are captured on a `cfgStart` pulse while idle. Later changes to them, and `cfgStart` pulses while busy, have no effect on the run in progress.
- R10: After reset, `busy`, `sliceValid`, `schedDone` and `streamEof` are all 0. Every new run restarts offsets, totals and the slice index from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgStart | input | 1 | Start pulse; captures the configuration when idle |
| cfgHeight | input | NSTRM*ROW_W | Frame height in rows; stream i at bits [i*ROW_W +: ROW_W] |
| cfgWidth | input | NSTRM*WID_W | Frame width in pixels; stream i at bits [i*WID_W +: WID_W] |
| cfgBurst | input | NSTRM*ROW_W | Maximum rows per slice; stream i at bits [i*ROW_W +: ROW_W] |
| cfgRdMult | input | MULT_W | Row multiplier for interleaved exposures |
| cfgPad | input | PAD_W | Pixels added to the width for read addressing |
| busy | output | 1 | A run is in progress |
| schedDone | output | 1 | One-cycle pulse when the run completes |
| sliceValid | output | 1 | Slice descriptor is being offered |
| sliceReady | input | 1 | Pipeline has finished the offered slice |
| sliceStream | output | STRM_W | Stream index of the slice |
| sliceIndex | output | SLC_W | Rotation (slice) number |
| sliceRows | output | ROW_W | Rows in the slice |
| sliceLast | output | 1 | End-of-frame flag of the dispatched stream |
| sliceRdOff | output | OFF_W | Read word offset of the slice |
| sliceWrOff | output | OFF_W | Write word offset of the slice |
| streamEof | output | NSTRM | Per-stream end-of-frame flags |

## Verification
The assertions assume that the pipeline raises `sliceReady` only while a descriptor is offered. They also assume that slice sizes and the row multiplier are nonzero, since a zero slice size would never shrink a nonzero remainder. The stimulus honours both conditions. It raises ready for a single cycle after a varying wait of zero to two cycles, and it uses only nonzero slice sizes and multipliers. One run scrambles the configuration inputs and pulses start while a slice is pending, to show that the captured values govern the run. Another run uses all-zero heights, so completion comes without a single dispatch.

// File: rtl/mss_pkg.sv
package mss_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVAL  = 2'd1,
    ST_ISSUE = 2'd2
  } mssState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture configuration, clear run state
    logic skip;    // zero-row visit: update flag, advance rotation
    logic latch;   // capture row count of the visit about to be issued
    logic commit;  // slice retired: update remainders, offsets, total
  } mssStrobe_t;

endpackage

// File: rtl/mss_ctrl.sv
module mss_ctrl
  import mss_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgStart,
  input  logic       allDone,
  input  logic       rowsZero,
  input  logic       sliceReady,
  output mssStrobe_t strobe,
  output logic       busy,
  output logic       sliceValid,
  output logic       schedDone
);

  mssState_e stateQ, stateD;

  always_comb begin
    stateD        = stateQ;
    strobe        = '0;
    schedDone     = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (cfgStart) begin
          strobe.load = 1'b1;
          stateD      = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (allDone) begin
          schedDone = 1'b1;
          stateD    = ST_IDLE;
        end else if (rowsZero) begin
          strobe.skip = 1'b1;
        end else begin
          strobe.latch = 1'b1;
          stateD       = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (sliceReady) begin
          strobe.commit = 1'b1;
          stateD        = ST_EVAL;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy       = (stateQ != ST_IDLE);
  assign sliceValid = (stateQ == ST_ISSUE);

endmodule

// File: rtl/mss_dpath.sv
module mss_dpath
  import mss_pkg::*;
#(
  parameter int NSTRM    = 4,
  parameter int ROW_W    = 12,
  parameter int WID_W    = 12,
  parameter int MULT_W   = 3,
  parameter int PAD_W    = 6,
  parameter int PPC_LOG2 = 0,
  parameter int SLC_W    = 12,
  parameter int OFF_W    = 32,
  localparam int STRM_W  = (NSTRM > 1) ? $clog2(NSTRM) : 1,
  localparam int TOT_W   = ROW_W + MULT_W + STRM_W + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  mssStrobe_t               strobe,
  input  logic [NSTRM*ROW_W-1:0]   cfgHeight,
  input  logic [NSTRM*WID_W-1:0]   cfgWidth,
  input  logic [NSTRM*ROW_W-1:0]   cfgBurst,
  input  logic [MULT_W-1:0]        cfgRdMult,
  input  logic [PAD_W-1:0]         cfgPad,
  output logic                     allDone,
  output logic                     rowsZero,
  output logic [STRM_W-1:0]        sliceStream,
  output logic [SLC_W-1:0]         sliceIndex,
  output logic [ROW_W-1:0]         sliceRows,
  output logic                     sliceLast,
  output logic [OFF_W-1:0]         sliceRdOff,
  output logic [OFF_W-1:0]         sliceWrOff,
  output logic [NSTRM-1:0]         streamEof
);

  localparam logic [STRM_W-1:0] LAST_STRM = STRM_W'(NSTRM - 1);

  // Unpacked views of the flat configuration inputs
  logic [ROW_W-1:0] heightIn [NSTRM];
  logic [WID_W-1:0] widthIn  [NSTRM];
  logic [ROW_W-1:0] burstIn  [NSTRM];

  genvar g;
  generate
    for (g = 0; g < NSTRM; g++) begin : g_unpack
      assign heightIn[g] = cfgHeight[g*ROW_W +: ROW_W];
      assign widthIn[g]  = cfgWidth[g*WID_W +: WID_W];
      assign burstIn[g]  = cfgBurst[g*ROW_W +: ROW_W];
    end
  endgenerate

  // Captured configuration
  logic [WID_W-1:0]  widthQ [NSTRM];
  logic [ROW_W-1:0]  burstQ [NSTRM];
  logic [MULT_W-1:0] multQ;
  logic [PAD_W-1:0]  padQ;

  // Run state
  logic [ROW_W-1:0]  remQ   [NSTRM];
  logic [OFF_W-1:0]  rdOffQ [NSTRM];
  logic [OFF_W-1:0]  wrOffQ [NSTRM];
  logic [TOT_W-1:0]  totalQ, grandQ;
  logic [STRM_W-1:0] ptrQ;
  logic [SLC_W-1:0]  sliceQ;
  logic [ROW_W-1:0]  rowsQ;
  logic [NSTRM-1:0]  eofQ;

  // Sum of scaled heights taken straight from the inputs at load time
  logic [TOT_W-1:0] grandD;
  always_comb begin
    grandD = '0;
    for (int i = 0; i < NSTRM; i++) begin
      grandD = grandD + TOT_W'(heightIn[i]) * TOT_W'(cfgRdMult);
    end
  end

  // Visit evaluation for the current stream
  logic [ROW_W-1:0] curRem, curBurst, evalRows;
  logic             takeBurst;
  always_comb begin
    curRem    = remQ[ptrQ];
    curBurst  = burstQ[ptrQ];
    takeBurst = (curRem > curBurst);
    evalRows  = takeBurst ? curBurst : curRem;
  end

  // Offset increments for the slice being retired
  logic [WID_W:0]   padWidth;
  logic [OFF_W-1:0] rdSpan, wrSpan, rdInc, wrInc;
  logic [TOT_W-1:0] scaledRows;
  always_comb begin
    padWidth   = (WID_W+1)'(widthQ[ptrQ]) + (WID_W+1)'(padQ);
    rdSpan     = OFF_W'(padWidth >> PPC_LOG2);
    wrSpan     = OFF_W'(widthQ[ptrQ] >> PPC_LOG2);
    rdInc      = (OFF_W'(multQ) * OFF_W'(rowsQ) * rdSpan) >> 2;
    wrInc      = (OFF_W'(rowsQ) * wrSpan) >> 2;
    scaledRows = TOT_W'(rowsQ) * TOT_W'(multQ);
  end

  logic advance;
  assign advance = strobe.skip | strobe.commit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NSTRM; i++) begin
        widthQ[i] <= '0;
        burstQ[i] <= '0;
        remQ[i]   <= '0;
        rdOffQ[i] <= '0;
        wrOffQ[i] <= '0;
      end
      multQ  <= '0;
      padQ   <= '0;
      totalQ <= '0;
      grandQ <= '0;
      ptrQ   <= '0;
      sliceQ <= '0;
      rowsQ  <= '0;
      eofQ   <= '0;
    end else if (strobe.load) begin
      for (int i = 0; i < NSTRM; i++) begin
        widthQ[i] <= widthIn[i];
        burstQ[i] <= burstIn[i];
        remQ[i]   <= heightIn[i];
        rdOffQ[i] <= '0;
        wrOffQ[i] <= '0;
      end
      multQ  <= cfgRdMult;
      padQ   <= cfgPad;
      totalQ <= '0;
      grandQ <= grandD;
      ptrQ   <= '0;
      sliceQ <= '0;
      rowsQ  <= '0;
      eofQ   <= '0;
    end else begin
      if (strobe.skip || strobe.latch) begin
        eofQ[ptrQ] <= ~takeBurst;
      end
      if (strobe.latch) begin
        rowsQ <= evalRows;
      end
      if (strobe.commit) begin
        remQ[ptrQ]   <= remQ[ptrQ] - rowsQ;
        rdOffQ[ptrQ] <= rdOffQ[ptrQ] + rdInc;
        wrOffQ[ptrQ] <= wrOffQ[ptrQ] + wrInc;
        totalQ       <= totalQ + scaledRows;
      end
      if (advance) begin
        if (ptrQ == LAST_STRM) begin
          ptrQ   <= '0;
          sliceQ <= sliceQ + 1'b1;
        end else begin
          ptrQ <= ptrQ + 1'b1;
        end
      end
    end
  end

  assign allDone     = (totalQ >= grandQ);
  assign rowsZero    = (evalRows == '0);
  assign sliceStream = ptrQ;
  assign sliceIndex  = sliceQ;
  assign sliceRows   = rowsQ;
  assign sliceLast   = eofQ[ptrQ];
  assign sliceRdOff  = rdOffQ[ptrQ];
  assign sliceWrOff  = wrOffQ[ptrQ];
  assign streamEof   = eofQ;

endmodule

// File: rtl/mstream_slice_sched.sv
module mstream_slice_sched
  import mss_pkg::*;
#(
  parameter int NSTRM    = 4,
  parameter int ROW_W    = 12,
  parameter int WID_W    = 12,
  parameter int MULT_W   = 3,
  parameter int PAD_W    = 6,
  parameter int PPC_LOG2 = 0,
  parameter int SLC_W    = 12,
  parameter int OFF_W    = 32,
  localparam int STRM_W  = (NSTRM > 1) ? $clog2(NSTRM) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgStart,
  input  logic [NSTRM*ROW_W-1:0] cfgHeight,
  input  logic [NSTRM*WID_W-1:0] cfgWidth,
  input  logic [NSTRM*ROW_W-1:0] cfgBurst,
  input  logic [MULT_W-1:0]      cfgRdMult,
  input  logic [PAD_W-1:0]       cfgPad,
  output logic                   busy,
  output logic                   schedDone,
  output logic                   sliceValid,
  input  logic                   sliceReady,
  output logic [STRM_W-1:0]      sliceStream,
  output logic [SLC_W-1:0]       sliceIndex,
  output logic [ROW_W-1:0]       sliceRows,
  output logic                   sliceLast,
  output logic [OFF_W-1:0]       sliceRdOff,
  output logic [OFF_W-1:0]       sliceWrOff,
  output logic [NSTRM-1:0]       streamEof
);

  mssStrobe_t strobe;
  logic       allDone, rowsZero;

  mss_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgStart   (cfgStart),
    .allDone    (allDone),
    .rowsZero   (rowsZero),
    .sliceReady (sliceReady),
    .strobe     (strobe),
    .busy       (busy),
    .sliceValid (sliceValid),
    .schedDone  (schedDone)
  );

  mss_dpath #(
    .NSTRM    (NSTRM),
    .ROW_W    (ROW_W),
    .WID_W    (WID_W),
    .MULT_W   (MULT_W),
    .PAD_W    (PAD_W),
    .PPC_LOG2 (PPC_LOG2),
    .SLC_W    (SLC_W),
    .OFF_W    (OFF_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cfgHeight   (cfgHeight),
    .cfgWidth    (cfgWidth),
    .cfgBurst    (cfgBurst),
    .cfgRdMult   (cfgRdMult),
    .cfgPad      (cfgPad),
    .allDone     (allDone),
    .rowsZero    (rowsZero),
    .sliceStream (sliceStream),
    .sliceIndex  (sliceIndex),
    .sliceRows   (sliceRows),
    .sliceLast   (sliceLast),
    .sliceRdOff  (sliceRdOff),
    .sliceWrOff  (sliceWrOff),
    .streamEof   (streamEof)
  );

endmodule

// File: rtl/mss_checker.sv
module mss_checker #(
  parameter int NSTRM  = 4,
  parameter int ROW_W  = 12,
  parameter int SLC_W  = 12,
  parameter int OFF_W  = 32,
  localparam int STRM_W = (NSTRM > 1) ? $clog2(NSTRM) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              schedDone,
  input logic              sliceValid,
  input logic              sliceReady,
  input logic [STRM_W-1:0] sliceStream,
  input logic [SLC_W-1:0]  sliceIndex,
  input logic [ROW_W-1:0]  sliceRows,
  input logic [OFF_W-1:0]  sliceRdOff,
  input logic [OFF_W-1:0]  sliceWrOff,
  input logic [NSTRM-1:0]  streamEof
);

  logic              haveLast;
  logic [STRM_W-1:0] lastStrm;
  logic [SLC_W-1:0]  lastSlc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveLast <= 1'b0;
      lastStrm <= '0;
      lastSlc  <= '0;
    end else if (schedDone) begin
      haveLast <= 1'b0;
    end else if (sliceValid && sliceReady) begin
      haveLast <= 1'b1;
      lastStrm <= sliceStream;
      lastSlc  <= sliceIndex;
    end
  end

  AST_ROTATION_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sliceValid) && haveLast) |->
      ((sliceIndex > lastSlc) || ((sliceIndex == lastSlc) && (sliceStream > lastStrm)))); // R1

  AST_NO_EMPTY_SLICE: assert property (@(posedge clk) disable iff (!rstN)
    sliceValid |-> (sliceRows != '0)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    schedDone |=> (!schedDone && !busy)); // R5

  AST_DONE_NOT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    schedDone |-> !sliceValid); // R5

  AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (sliceValid && !sliceReady) |=>
      (sliceValid && $stable(sliceStream) && $stable(sliceIndex) && $stable(sliceRows)
       && $stable(sliceRdOff) && $stable(sliceWrOff))); // R8

  AST_RETIRE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (sliceValid && sliceReady) |=> !sliceValid); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sliceValid && !schedDone)); // R10

endmodule

bind mstream_slice_sched mss_checker #(
  .NSTRM (NSTRM),
  .ROW_W (ROW_W),
  .SLC_W (SLC_W),
  .OFF_W (OFF_W)
) u_mss_checker (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .schedDone   (schedDone),
  .sliceValid  (sliceValid),
  .sliceReady  (sliceReady),
  .sliceStream (sliceStream),
  .sliceIndex  (sliceIndex),
  .sliceRows   (sliceRows),
  .sliceRdOff  (sliceRdOff),
  .sliceWrOff  (sliceWrOff),
  .streamEof   (streamEof)
);

// File: tb/mstream_slice_sched_bench.sv
module mstream_slice_sched_bench;

  localparam int NS = 4, RW = 12, WW = 12, MW = 3, PW = 6, PPCL = 0, SW = 12, OW = 32;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rstN, cfgStart, sliceReady;
  logic [NS*RW-1:0]  cfgHeight, cfgBurst;
  logic [NS*WW-1:0]  cfgWidth;
  logic [MW-1:0]     cfgRdMult;
  logic [PW-1:0]     cfgPad;
  logic              busy, schedDone, sliceValid, sliceLast;
  logic [1:0]        sliceStream;
  logic [SW-1:0]     sliceIndex;
  logic [RW-1:0]     sliceRows;
  logic [OW-1:0]     sliceRdOff, sliceWrOff;
  logic [NS-1:0]     streamEof;

  mstream_slice_sched #(
    .NSTRM(NS), .ROW_W(RW), .WID_W(WW), .MULT_W(MW), .PAD_W(PW),
    .PPC_LOG2(PPCL), .SLC_W(SW), .OFF_W(OW)
  ) u_mstream_slice_sched (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .cfgHeight(cfgHeight),
    .cfgWidth(cfgWidth), .cfgBurst(cfgBurst), .cfgRdMult(cfgRdMult), .cfgPad(cfgPad),
    .busy(busy), .schedDone(schedDone), .sliceValid(sliceValid), .sliceReady(sliceReady),
    .sliceStream(sliceStream), .sliceIndex(sliceIndex), .sliceRows(sliceRows),
    .sliceLast(sliceLast), .sliceRdOff(sliceRdOff), .sliceWrOff(sliceWrOff),
    .streamEof(streamEof)
  );

  typedef struct {
    int strm; int slc; int rows; int last; int rd; int wr;
  } desc_t;

  desc_t expQ[$];
  int    expEof[NS];
  int    nChecks = 0, nErrors = 0, cycles = 0;
  bit    timedOut = 0;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Per-clock comparison of the offered descriptor against the model
  always @(negedge clk) begin
    if (rstN && sliceValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R4", "unexpected dispatch stream", int'(sliceStream), -1);
      end else begin
        check(int'(sliceStream) == expQ[0].strm, "R1", "stream", int'(sliceStream), expQ[0].strm);
        check(int'(sliceIndex) == expQ[0].slc, "R1", "slice index", int'(sliceIndex), expQ[0].slc);
        check(int'(sliceRows) == expQ[0].rows, "R2", "rows", int'(sliceRows), expQ[0].rows);
        check(int'(sliceLast) == expQ[0].last, "R3", "last flag", int'(sliceLast), expQ[0].last);
        check(int'(sliceRdOff) == expQ[0].rd, "R6", "read offset", int'(sliceRdOff), expQ[0].rd);
        check(int'(sliceWrOff) == expQ[0].wr, "R7", "write offset (R8 hold)", int'(sliceWrOff), expQ[0].wr);
      end
    end
  end

  // Behavioural model: builds the expected dispatch list and final flags
  task automatic buildModel(input int h[NS], input int w[NS], input int b[NS],
                            input int m, input int pad);
    int rem[NS], rd[NS], wr[NS];
    int tot, grand, s, sl, rows;
    desc_t d;
    expQ.delete();
    grand = 0;
    for (int i = 0; i < NS; i++) begin
      rem[i] = h[i]; rd[i] = 0; wr[i] = 0; expEof[i] = 0;
      grand += h[i] * m;
    end
    tot = 0; s = 0; sl = 0;
    while (tot < grand) begin
      if (rem[s] > b[s]) begin rows = b[s]; expEof[s] = 0; end
      else begin rows = rem[s]; expEof[s] = 1; end
      if (rows > 0) begin
        d.strm = s; d.slc = sl; d.rows = rows; d.last = expEof[s];
        d.rd = rd[s]; d.wr = wr[s];
        expQ.push_back(d);
      end
      rd[s] += (m * rows * ((w[s] + pad) >> PPCL)) / 4;
      wr[s] += (rows * (w[s] >> PPCL)) / 4;
      rem[s] -= rows;
      tot += rows * m;
      if (s == NS - 1) begin s = 0; sl++; end else s++;
    end
  endtask

  task automatic drive(input int h[NS], input int w[NS], input int b[NS],
                       input int m, input int pad);
    for (int i = 0; i < NS; i++) begin
      cfgHeight[i*RW +: RW] = RW'(h[i]);
      cfgWidth[i*WW +: WW]  = WW'(w[i]);
      cfgBurst[i*RW +: RW]  = RW'(b[i]);
    end
    cfgRdMult = MW'(m);
    cfgPad    = PW'(pad);
  endtask

  task automatic runScen(input int h[NS], input int w[NS], input int b[NS],
                         input int m, input int pad, input bit scramble);
    int nExp, disp, eofVec;
    bit finished;
    buildModel(h, w, b, m, pad);
    nExp = expQ.size();
    disp = 0;
    finished = 0;
    @(negedge clk);
    drive(h, w, b, m, pad);
    cfgStart = 1'b1;
    @(negedge clk);
    cfgStart = 1'b0;
    if (scramble) begin
      drive('{9, 9, 9, 9}, '{60, 60, 60, 60}, '{1, 1, 1, 1}, 5, 17);
    end
    while (!finished && cycles < LIMIT) begin
      if (schedDone) begin
        finished = 1;
      end else if (sliceValid) begin
        if (disp == 0) begin
          check(sliceRdOff == '0 && sliceWrOff == '0, "R10", "first offsets of run",
                int'(sliceRdOff + sliceWrOff), 0);
        end
        if (scramble && disp == 1) begin
          cfgStart = 1'b1;   // R9: start while busy must be ignored
          @(negedge clk);
          cfgStart = 1'b0;
        end
        repeat (disp % 3) @(negedge clk);
        sliceReady = 1'b1;
        @(negedge clk);
        sliceReady = 1'b0;
        if (expQ.size() > 0) void'(expQ.pop_front());
        disp++;
      end else begin
        @(negedge clk);
      end
    end
    if (!finished) begin
      timedOut = 1;
      check(1'b0, "R5", "watchdog expired", cycles, LIMIT);
    end else begin
      check(disp == nExp, "R4", "dispatch count", disp, nExp);
      @(negedge clk);
      check(!busy && !schedDone, "R5", "idle after done pulse", int'({busy, schedDone}), 0);
      eofVec = 0;
      for (int i = 0; i < NS; i++) eofVec |= (expEof[i] << i);
      check(int'(streamEof) == eofVec, "R3", "final end-of-frame flags", int'(streamEof), eofVec);
    end
  endtask

  initial begin
    rstN = 1'b0; cfgStart = 1'b0; sliceReady = 1'b0;
    cfgHeight = '0; cfgWidth = '0; cfgBurst = '0; cfgRdMult = '0; cfgPad = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !sliceValid && !schedDone, "R10", "reset outputs",
          int'({busy, sliceValid, schedDone}), 0);
    check(streamEof == '0, "R10", "reset flags", int'(streamEof), 0);

    // Mixed slice sizes, one empty stream, unit multiplier
    if (!timedOut) runScen('{5, 3, 8, 0}, '{16, 32, 8, 24}, '{2, 4, 3, 1}, 1, 0, 1'b0);
    // Multiplier and padding, scrambled inputs and start while busy (R9)
    if (!timedOut) runScen('{4, 7, 1, 6}, '{20, 12, 36, 8}, '{4, 2, 1, 5}, 2, 4, 1'b1);
    // All heights zero: completion with no dispatch
    if (!timedOut) runScen('{0, 0, 0, 0}, '{8, 8, 8, 8}, '{1, 1, 1, 1}, 1, 0, 1'b0);
    // Heights exact multiples of slice sizes, truncating offsets
    if (!timedOut) runScen('{6, 4, 9, 2}, '{40, 10, 6, 22}, '{3, 4, 3, 2}, 3, 2, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule